// File: doc/BRIEF.md
# Banked-Register Exception Context Switcher

This block sits in the control path of a small CPU core and owns the programmer-visible register state. That state is held as four structurally identical banks of general registers. Each bank has its own privilege word. Bank 0 serves the hypervisor, bank 1 kernel services, bank 2 a nested OS or drivers, and bank 3 user code. The banks differ only in what their privilege words contain.

When an exception is pending and not blocked, the block switches context within a single clock edge and saves no registers. It records the interrupted bank and instruction address in a one-level shadow. It makes bank 0 active and blocks further exceptions. It asks the fetch logic to load the handler address, which is the vector base plus four times the cause code. It also writes the cause code into register 0 of bank 0. A return strobe undoes the switch: it reactivates the saved bank, reloads the saved address and lifts the block. Code in a privileged bank may rewrite the saved return context before returning, which is how control first reaches a lower bank.

Top module: `bank_ctx_switch`

## Requirements
- R1: After synchronous reset the active bank is 0 and exceptions are unblocked. `ip_load` is 0 and `ip_next` is 0. The privilege word of bank 0 is all ones and those of banks 1 to 3 are zero.
- R2: If exceptions are unblocked and any cause is pending at a clock edge, then after that edge the active bank is 0, `exc_masked` is 1, `ip_load` is 1 for one cycle, and `ip_next` equals `vec_base` + 4 × cause code.
- R3: Cause codes are the bit positions of `exc_req`: 0 page fault, 1 access violation, 2 system call, 3 preemption, 4 peripheral request. When several are pending, the lowest code is taken.
- R4: On entry the cause code, zero-extended, is written to register 0 of bank 0. A general register write requested in the same cycle is discarded.
- R5: While `exc_masked` is 1, pending causes have no effect. The active bank and the mask stay unchanged and `ip_load` stays 0 until a return.
- R6: A `reti` while `exc_masked` is 1 restores the saved bank. It drives `ip_load` = 1 with `ip_next` equal to the saved return address, and clears `exc_masked`, all in one cycle. The saved context is the bank and `cur_ip` at entry, unless it was rewritten later.
- R7: A `reti` while exceptions are unblocked is ignored. Bank, mask and `ip_load` stay unchanged.
- R8: `priv_flags` always shows the privilege word of the active bank. A write through `priv_we` from a privileged bank updates the word of bank `priv_bank`.
- R9: In bank 3 a write through `priv_we` or `ret_we` is discarded and raises an access violation (code 1) in the same cycle.
- R10: General register writes and reads address only the active bank. `rd_data` is registered and shows, one cycle later, the contents at the edge. A read of an address written at the same edge returns the old value.
- R11: A write through `ret_we` from banks 0 to 2 replaces the saved return bank and address. A following `reti` uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | NCAUSE | Pending causes, bit index = cause code |
| vec_base | input | IPW | Handler vector base address |
| cur_ip | input | IPW | Address of the instruction being interrupted |
| reti | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | RAW | General register write index |
| wr_data | input | DW | General register write data |
| rd_addr | input | RAW | General register read index |
| priv_we | input | 1 | Privilege word write enable |
| priv_bank | input | 2 | Bank whose privilege word is written |
| priv_wdata | input | PW | Privilege word write data |
| ret_we | input | 1 | Saved return context write enable |
| ret_bank | input | 2 | New saved return bank |
| ret_ip | input | IPW | New saved return address |
| act_bank | output | 2 | Active bank index |
| priv_flags | output | PW | Privilege word of the active bank |
| exc_masked | output | 1 | Exceptions blocked |
| ip_load | output | 1 | One-cycle request to load `ip_next` |
| ip_next | output | IPW | Handler or return address |
| rd_data | output | DW | Registered read data |

## Verification
The bound checker tests the mode-change rules on every cycle. Entry lands in bank 0 with the mask and the load request set. A pending page fault selects the vector base itself. The bank and the mask hold still while masked and no return arrives. A return restores the shadowed bank. A return while unmasked does nothing. A privileged write from bank 3 traps into bank 0. The bench scenarios alone show the data-dependent results. These are the priority among mixed causes, the exact vector offsets, the cause code in register 0 of bank 0, and the write dropped on entry. They also cover bank isolation of the register file, privilege words that follow the active bank, and a rewritten return context.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int NBANK     = 4;
  localparam int BW        = 2;
  localparam int NCAUSE    = 5;
  localparam int CW        = 3;
  localparam int HV_BANK   = 0;
  localparam int USER_BANK = NBANK - 1;

  typedef logic [BW-1:0] bank_t;

  typedef enum logic [CW-1:0] {
    C_PFAULT  = 3'd0,
    C_ACCESS  = 3'd1,
    C_SYSCALL = 3'd2,
    C_PREEMPT = 3'd3,
    C_PERIPH  = 3'd4
  } cause_e;
endpackage

// File: rtl/ctx_cause_pick.sv
module ctx_cause_pick
  import ctx_pkg::*;
(
  input  logic [NCAUSE-1:0] pend,
  output logic              any,
  output logic [CW-1:0]     code
);
  // lowest code wins (R3): scan from the top so the last hit is the lowest
  always_comb begin
    code = '0;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (pend[i]) code = CW'(i);
    end
    any = |pend;
  end
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read, read-before-write: RAM-inferable
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_priv_bank.sv
module ctx_priv_bank
  import ctx_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  bank_t         wbank,
  input  logic [PW-1:0] wdata,
  input  bank_t         sel,
  output logic [PW-1:0] flags
);
  logic [PW-1:0] word_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [PW-1:0] RST_VAL = (b == HV_BANK) ? {PW{1'b1}} : {PW{1'b0}};
    always_ff @(posedge clk) begin
      if (rst)                         word_q[b] <= RST_VAL;
      else if (we && wbank == BW'(b))  word_q[b] <= wdata;
    end
  end

  assign flags = word_q[sel];
endmodule

// File: rtl/bank_ctx_switch.sv
module bank_ctx_switch
  import ctx_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int IPW  = 32,
  parameter int PW   = 8,
  localparam int RAW = $clog2(NREG),
  localparam int FAW = BW + RAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] exc_req,
  input  logic [IPW-1:0]    vec_base,
  input  logic [IPW-1:0]    cur_ip,
  input  logic              reti,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [RAW-1:0]    rd_addr,
  input  logic              priv_we,
  input  logic [BW-1:0]     priv_bank,
  input  logic [PW-1:0]     priv_wdata,
  input  logic              ret_we,
  input  logic [BW-1:0]     ret_bank,
  input  logic [IPW-1:0]    ret_ip,
  output logic [BW-1:0]     act_bank,
  output logic [PW-1:0]     priv_flags,
  output logic              exc_masked,
  output logic              ip_load,
  output logic [IPW-1:0]    ip_next,
  output logic [DW-1:0]     rd_data
);
  bank_t          bank_q, sbank_q;
  logic [IPW-1:0] sip_q;
  logic           masked_q, ip_load_q;
  logic [IPW-1:0] ip_next_q;

  logic              user_mode, cfg_bad, take, leave, any;
  logic [NCAUSE-1:0] pend;
  logic [CW-1:0]     code;

  // privileged writes from the user bank turn into an access violation (R9)
  assign user_mode = (bank_q == BW'(USER_BANK));
  assign cfg_bad   = user_mode && (priv_we || ret_we);
  assign pend      = exc_req | (NCAUSE'(cfg_bad) << C_ACCESS);

  ctx_cause_pick u_pick (
    .pend (pend),
    .any  (any),
    .code (code)
  );

  assign take  = !masked_q && any;
  assign leave = !take && masked_q && reti;

  // control state: one-edge entry and return
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q    <= BW'(HV_BANK);
      sbank_q   <= BW'(HV_BANK);
      sip_q     <= '0;
      masked_q  <= 1'b0;
      ip_load_q <= 1'b0;
      ip_next_q <= '0;
    end else begin
      ip_load_q <= take || leave;
      if (take) begin
        sbank_q   <= bank_q;
        sip_q     <= cur_ip;
        bank_q    <= BW'(HV_BANK);
        masked_q  <= 1'b1;
        ip_next_q <= vec_base + (IPW'(code) << 2);
      end else begin
        if (leave) begin
          bank_q    <= sbank_q;
          masked_q  <= 1'b0;
          ip_next_q <= sip_q;
        end
        if (ret_we && !user_mode) begin
          sbank_q <= ret_bank;
          sip_q   <= ret_ip;
        end
      end
    end
  end

  // register file: entry owns the only write port for the cause code (R4)
  logic          rf_we;
  logic [FAW-1:0] rf_waddr, rf_raddr;
  logic [DW-1:0]  rf_wdata;

  always_comb begin
    if (take) begin
      rf_we    = 1'b1;
      rf_waddr = {BW'(HV_BANK), RAW'(0)};
      rf_wdata = DW'(code);
    end else begin
      rf_we    = wr_en;
      rf_waddr = {bank_q, wr_addr};
      rf_wdata = wr_data;
    end
  end
  assign rf_raddr = {bank_q, rd_addr};

  ctx_regfile #(.DW(DW), .DEPTH(NBANK * NREG)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rd_data)
  );

  ctx_priv_bank #(.PW(PW)) u_priv (
    .clk   (clk),
    .rst   (rst),
    .we    (priv_we && !user_mode && !take),
    .wbank (priv_bank),
    .wdata (priv_wdata),
    .sel   (bank_q),
    .flags (priv_flags)
  );

  assign act_bank   = bank_q;
  assign exc_masked = masked_q;
  assign ip_load    = ip_load_q;
  assign ip_next    = ip_next_q;
endmodule

// File: rtl/ctx_switch_chk.sv
module ctx_switch_chk
  import ctx_pkg::*;
#(
  parameter int IPW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NCAUSE-1:0] exc_req,
  input logic [IPW-1:0]    vec_base,
  input logic              reti,
  input logic              priv_we,
  input logic              ret_we,
  input logic [BW-1:0]     act_bank,
  input logic              exc_masked,
  input logic              ip_load,
  input logic [IPW-1:0]    ip_next,
  input logic [BW-1:0]     sbank_q
);
  logic user_cfg;
  assign user_cfg = (act_bank == BW'(USER_BANK)) && (priv_we || ret_we);

  p_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (!exc_masked && (|exc_req)) |=> (exc_masked && act_bank == BW'(HV_BANK) && ip_load));

  p_pfault_vec_r3: assert property (@(posedge clk) disable iff (rst)
    (!exc_masked && exc_req[C_PFAULT]) |=> (ip_next == $past(vec_base)));

  p_hold_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (exc_masked && !reti) |=> (exc_masked && $stable(act_bank) && !ip_load));

  p_return_r6: assert property (@(posedge clk) disable iff (rst)
    (exc_masked && reti) |=> (!exc_masked && ip_load && act_bank == $past(sbank_q)));

  p_stray_reti_r7: assert property (@(posedge clk) disable iff (rst)
    (!exc_masked && !(|exc_req) && !user_cfg && reti) |=>
      (!exc_masked && !ip_load && $stable(act_bank)));

  p_user_trap_r9: assert property (@(posedge clk) disable iff (rst)
    (!exc_masked && user_cfg) |=> (exc_masked && act_bank == BW'(HV_BANK)));
endmodule

bind bank_ctx_switch ctx_switch_chk #(.IPW(IPW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exc_req    (exc_req),
  .vec_base   (vec_base),
  .reti       (reti),
  .priv_we    (priv_we),
  .ret_we     (ret_we),
  .act_bank   (act_bank),
  .exc_masked (exc_masked),
  .ip_load    (ip_load),
  .ip_next    (ip_next),
  .sbank_q    (sbank_q)
);

// File: tb/bank_ctx_switch_tb.sv
module bank_ctx_switch_tb;
  localparam int NREG = 8;
  localparam int DW   = 32;
  localparam int IPW  = 32;
  localparam int PW   = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic [4:0]      exc_req;
  logic [IPW-1:0]  vec_base, cur_ip, ret_ip;
  logic            reti, wr_en, priv_we, ret_we;
  logic [2:0]      wr_addr, rd_addr;
  logic [DW-1:0]   wr_data;
  logic [1:0]      priv_bank, ret_bank;
  logic [PW-1:0]   priv_wdata;
  logic [1:0]      act_bank;
  logic [PW-1:0]   priv_flags;
  logic            exc_masked, ip_load;
  logic [IPW-1:0]  ip_next;
  logic [DW-1:0]   rd_data;

  always #4 clk = ~clk;

  bank_ctx_switch #(.NREG(NREG), .DW(DW), .IPW(IPW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .vec_base(vec_base), .cur_ip(cur_ip),
    .reti(reti), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .priv_we(priv_we), .priv_bank(priv_bank), .priv_wdata(priv_wdata),
    .ret_we(ret_we), .ret_bank(ret_bank), .ret_ip(ret_ip),
    .act_bank(act_bank), .priv_flags(priv_flags), .exc_masked(exc_masked),
    .ip_load(ip_load), .ip_next(ip_next), .rd_data(rd_data)
  );

  // behavioural reference state
  int        m_bank, m_sbank, m_masked, m_ipl;
  int        m_sip, m_ipn;
  logic [31:0] m_mem [32];
  bit        m_known [32];
  int        m_priv [4];
  logic [31:0] m_rd;
  bit        m_rd_ok;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  task automatic cmp(string what, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("act_bank", act_bank, m_bank);
    cmp("exc_masked", exc_masked, m_masked);
    cmp("priv_flags", priv_flags, m_priv[m_bank]);
    cmp("ip_load", ip_load, m_ipl);
    if (m_ipl != 0) cmp("ip_next", ip_next, m_ipn);
    if (m_rd_ok) cmp("rd_data", rd_data, m_rd);
  endtask

  task automatic model_edge();
    int pend, code, ob, take;
    ob   = m_bank;
    pend = exc_req;
    if (ob == 3 && (priv_we || ret_we)) pend = pend | 2;
    code = 0;
    for (int i = 4; i >= 0; i--) if (pend[i]) code = i;
    take = (m_masked == 0) && (pend != 0);
    m_rd_ok = m_known[ob*8 + rd_addr];
    m_rd    = m_mem[ob*8 + rd_addr];
    m_ipl   = 0;
    if (take) begin
      m_sbank  = ob;
      m_sip    = cur_ip;
      m_bank   = 0;
      m_masked = 1;
      m_ipl    = 1;
      m_ipn    = vec_base + code * 4;
      m_mem[0] = code;
      m_known[0] = 1;
    end else begin
      int sb, si;
      sb = m_sbank; si = m_sip;
      if (reti && m_masked == 1) begin
        m_bank = sb; m_masked = 0; m_ipl = 1; m_ipn = si;
      end
      if (wr_en) begin
        m_mem[ob*8 + wr_addr] = wr_data;
        m_known[ob*8 + wr_addr] = 1;
      end
      if (priv_we && ob != 3) m_priv[priv_bank] = priv_wdata;
      if (ret_we && ob != 3) begin m_sbank = ret_bank; m_sip = ret_ip; end
    end
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    exc_req = '0; reti = 0; wr_en = 0; priv_we = 0; ret_we = 0;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d; step(); wr_en = 0;
  endtask

  task automatic rd(int a);
    rd_addr = 3'(a); step(); step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1; vec_base = 32'h0000_4000; cur_ip = 32'h0000_1000; ret_ip = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0; priv_bank = 0; priv_wdata = 0; ret_bank = 0;
    m_bank = 0; m_sbank = 0; m_masked = 0; m_ipl = 0; m_sip = 0; m_ipn = 0; m_rd_ok = 0;
    m_priv[0] = 8'hFF; m_priv[1] = 0; m_priv[2] = 0; m_priv[3] = 0;
    for (int i = 0; i < 32; i++) begin m_known[i] = 0; m_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    tag = "R1";
    compare_all();
    cmp("ip_next", ip_next, 0);
    step();

    // R10: register file in bank 0
    tag = "R10";
    for (int i = 0; i < 8; i++) wr(i, 32'hA000 + i);
    for (int i = 0; i < 8; i++) rd(i);
    // read and write same address at one edge returns old value
    wr_en = 1; wr_addr = 3; wr_data = 32'h3333; rd_addr = 3; step(); wr_en = 0; step();

    // R8: privilege words written from bank 0
    tag = "R8";
    priv_we = 1;
    priv_bank = 1; priv_wdata = 8'h0F; step();
    priv_bank = 2; priv_wdata = 8'h07; step();
    priv_bank = 3; priv_wdata = 8'h01; step();
    priv_we = 0; step();

    // R7: stray return while unmasked
    tag = "R7";
    reti = 1; step(); reti = 0; step();

    // R2: syscall entry from bank 0
    tag = "R2";
    cur_ip = 32'h0000_1234; exc_req = 5'b00100; step(); exc_req = 0; step();
    rd(0);

    // R11: rewrite return context, then R6 return into bank 3
    tag = "R11";
    ret_we = 1; ret_bank = 3; ret_ip = 32'h0000_2000; step(); ret_we = 0;
    tag = "R6";
    reti = 1; step(); reti = 0; step();

    // R10: bank 3 is isolated from bank 0
    tag = "R10";
    for (int i = 0; i < 4; i++) wr(i, 32'hB300 + i);
    for (int i = 0; i < 4; i++) rd(i);
    rd(5);

    // R9: privilege write from user bank traps, word unchanged
    tag = "R9";
    cur_ip = 32'h0000_2040;
    priv_we = 1; priv_bank = 3; priv_wdata = 8'hFF; step(); priv_we = 0;
    tag = "R4";
    rd(0);
    tag = "R6";
    reti = 1; step(); reti = 0; step();
    tag = "R9";
    ret_we = 1; ret_bank = 0; ret_ip = 32'h0000_9999; step(); ret_we = 0;
    reti = 1; step(); reti = 0; step();

    // R3: priority among mixed causes, from bank 3
    tag = "R3";
    exc_req = 5'b11000; step(); exc_req = 0;
    reti = 1; step(); reti = 0;
    exc_req = 5'b10000; step(); exc_req = 0;
    reti = 1; step(); reti = 0;
    exc_req = 5'b11111; step(); exc_req = 0;
    rd(0);

    // R5: requests ignored while masked
    tag = "R5";
    exc_req = 5'b00011; step(); step(); step(); exc_req = 0;
    tag = "R6";
    reti = 1; step(); reti = 0; step();

    // R4: write in entry cycle is discarded
    tag = "R4";
    wr_en = 1; wr_addr = 2; wr_data = 32'hDEAD; exc_req = 5'b01000; step();
    wr_en = 0; exc_req = 0;
    rd(0); rd(2);
    reti = 1; step(); reti = 0;
    rd(2);

    // R8: priv_flags follow the bank, bank 1 via return context
    tag = "R8";
    exc_req = 5'b00100; step(); exc_req = 0;
    ret_we = 1; ret_bank = 1; ret_ip = 32'h0000_0500; step(); ret_we = 0;
    reti = 1; step(); reti = 0; step();
    cmp("priv_flags bank1", priv_flags, 8'h0F);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule